// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block is the rename stage of an out-of-order core whose physical register file holds both committed and speculative values. Each cycle it can take a group of up to two decoded instructions. Each instruction names one destination and two source architectural registers. For every instruction in the group the block returns:

- the physical registers that currently hold the newest values of its sources;
- a freshly allocated physical destination;
- the physical register its destination was mapped to before this rename.

That last value travels with the instruction to commit. When the instruction commits, the reorder buffer hands it back to this block, and the block returns it to the pool of free registers.

Free physical registers sit in a circular queue. New destinations are taken from the head of the queue. Registers returned at commit are appended at the tail. When the second instruction of a group depends on the first, the dependence is resolved inside the group, without waiting a cycle.

A branch in the group can ask for a checkpoint. The checkpoint copies the whole mapping table and the free-queue head pointer, and the block returns a small tag that names it. On a mispredict, the tag restores both in one cycle. Restoring the head pointer reclaims every register that was allocated after the branch.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The 24 free registers are handed out in the order 8, 9, 10 and so on up to 31.
- R2: Each source output is the current table mapping of its architectural source. An instruction accepted in cycle t is visible to a group presented in cycle t+1.
- R3: A slot that is valid and has `in_wr_i` set receives the physical register at the free-queue head. When both slots allocate, slot 0 takes the head entry and slot 1 takes the next entry. A group is accepted when `ready_o` is 1 and at least one `in_vld_i` bit is set.
- R4: A valid slot with `in_wr_i` clear allocates nothing. It reports 0 on both its destination and its previous-mapping outputs, and slot 1 then takes the head entry.
- R5: When slot 0 allocates and slot 1 reads slot 0's architectural destination as either source, slot 1's source output is slot 0's new physical register.
- R6: When both slots write the same architectural register:
  - slot 1's previous mapping is slot 0's new physical register;
  - the table ends up holding slot 1's register.
- R7: `ready_o` is 0 whenever the number of allocating slots exceeds the free count. A stalled group changes no state. The free count is taken before any of the same cycle's commit returns are added.
- R8: Each set bit of `cmt_vld_i` appends the matching 5-bit field of `cmt_preg_i` (bit 0 is slot 0) to the tail of the free queue. Slot 0's register is appended before slot 1's.
- R9: `ckpt_req_i` with an accepted group stores the table and the head pointer as they stand after that group. `ckpt_tag_o` reports the tag of the stored snapshot. Tags are handed out in increasing order modulo 4. While 4 snapshots are outstanding, a checkpoint request holds `ready_o` at 0.
- R10: `flush_i` does three things:
  - it restores the table and the free-queue head from snapshot `flush_tag_i`;
  - it releases that snapshot and every younger one;
  - it holds `ready_o` at 0, so the group presented in that cycle is dropped.
- R11: `ckpt_rel_i` releases the oldest outstanding snapshot. A release is ignored in a cycle where `flush_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 2 | Slot holds an instruction, bit 0 is slot 0 |
| in_wr_i | input | 2 | Slot writes a destination register |
| in_dst_i | input | 6 | Architectural destinations, 3 bits per slot |
| in_src1_i | input | 6 | First architectural sources |
| in_src2_i | input | 6 | Second architectural sources |
| ready_o | output | 1 | Group can be accepted this cycle |
| out_psrc1_o | output | 10 | Physical first sources, 5 bits per slot |
| out_psrc2_o | output | 10 | Physical second sources |
| out_pdst_o | output | 10 | Newly allocated physical destinations |
| out_pold_o | output | 10 | Previous destination mappings |
| cmt_vld_i | input | 2 | Commit return valid per lane |
| cmt_preg_i | input | 10 | Physical registers returned at commit |
| ckpt_req_i | input | 1 | Take a snapshot with this group |
| ckpt_tag_o | output | 2 | Tag of the snapshot being taken |
| ckpt_rel_i | input | 1 | Release the oldest snapshot |
| flush_i | input | 1 | Mispredict restore |
| flush_tag_i | input | 2 | Snapshot to restore |

## Verification
The bench builds the block with its default parameters: 8 architectural registers, 32 physical registers, 4 snapshots and 2 commit lanes. With only 24 free registers, a dozen two-allocation groups drain the free queue. This reaches the stall boundary, and it also covers a commit arriving in the same cycle as a stalled request.

Four snapshot slots are few enough that the bench can fill the snapshot queue, stall on it, release the oldest snapshot and see the tags wrap around. It also restores a middle tag while a release is asserted in the same cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_NUM_AREG = 8;
  localparam int unsigned RN_NUM_PHYS = 32;
  localparam int unsigned RN_NUM_SNAP = 4;
  localparam int unsigned RN_CMT_W    = 2;

  function automatic logic [1:0] rn_pop2(input logic [1:0] b);
    return {1'b0, b[0]} + {1'b0, b[1]};
  endfunction
endpackage

// File: rtl/rn_snap_ctl.sv
module rn_snap_ctl #(
  parameter int unsigned NUM_SNAP = 4,
  localparam int unsigned SW = $clog2(NUM_SNAP),
  localparam int unsigned CW = SW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          rel_i,
  input  logic          restore_i,
  input  logic [SW-1:0] restore_tag_i,
  output logic [SW-1:0] tag_o,
  output logic          full_o
);
  logic [SW-1:0] old_q;
  logic [CW-1:0] cnt_q;
  logic          dec;

  assign tag_o  = old_q + cnt_q[SW-1:0];
  assign full_o = (cnt_q == CW'(NUM_SNAP));
  assign dec    = rel_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
      cnt_q <= '0;
    end else if (restore_i) begin
      // keep everything older than the restored tag
      cnt_q <= CW'(SW'(restore_tag_i - old_q));
    end else begin
      if (dec) old_q <= old_q + 1'b1;
      cnt_q <= cnt_q + CW'(take_i) - CW'(dec);
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_AREG = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned NUM_SNAP = 4,
  parameter int unsigned NUM_RD   = 6,
  localparam int unsigned AW = $clog2(NUM_AREG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned SW = $clog2(NUM_SNAP)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_RD-1:0][AW-1:0]  rd_areg_i,
  output logic [NUM_RD-1:0][PW-1:0]  rd_preg_o,
  input  logic [1:0]                 wr_en_i,
  input  logic [1:0][AW-1:0]         wr_areg_i,
  input  logic [1:0][PW-1:0]         wr_preg_i,
  input  logic                       snap_take_i,
  input  logic [SW-1:0]              snap_tag_i,
  input  logic                       restore_i,
  input  logic [SW-1:0]              restore_tag_i
);
  logic [PW-1:0] map_q  [NUM_AREG];
  logic [PW-1:0] map_d  [NUM_AREG];
  logic [PW-1:0] snap_q [NUM_SNAP][NUM_AREG];

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_preg_o[r] = map_q[rd_areg_i[r]];
  end

  // slot 1 applied last so it wins on equal destinations
  always_comb begin
    map_d = map_q;
    for (int s = 0; s < 2; s++) begin
      if (wr_en_i[s]) map_d[wr_areg_i[s]] = wr_preg_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_AREG; i++) begin
        map_q[i] <= PW'(i);
        for (int k = 0; k < NUM_SNAP; k++) snap_q[k][i] <= PW'(i);
      end
    end else begin
      if (restore_i) map_q <= snap_q[restore_tag_i];
      else           map_q <= map_d;
      if (snap_take_i) snap_q[snap_tag_i] <= map_d;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int unsigned NUM_AREG = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned NUM_SNAP = 4,
  parameter int unsigned CMT_W    = 2,
  localparam int unsigned PW    = $clog2(NUM_PHYS),
  localparam int unsigned CW    = PW + 1,
  localparam int unsigned SW    = $clog2(NUM_SNAP),
  localparam int unsigned NFREE = NUM_PHYS - NUM_AREG
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lead_i,
  input  logic [1:0]                 alloc_i,
  output logic [1:0][PW-1:0]         preg_o,
  output logic [CW-1:0]              free_cnt_o,
  input  logic [CMT_W-1:0]           ret_vld_i,
  input  logic [CMT_W-1:0][PW-1:0]   ret_preg_i,
  input  logic                       snap_take_i,
  input  logic [SW-1:0]              snap_tag_i,
  input  logic                       restore_i,
  input  logic [SW-1:0]              restore_tag_i
);
  logic [PW-1:0] fifo_q [NUM_PHYS];
  logic [CW-1:0] head_q, tail_q, head_d, idx1;
  logic [CW-1:0] snap_head_q [NUM_SNAP];
  logic [CW-1:0] wr_ptr [CMT_W];
  logic [CW-1:0] ret_num;

  assign idx1       = head_q + CW'(lead_i);
  assign preg_o[0]  = fifo_q[head_q[PW-1:0]];
  assign preg_o[1]  = fifo_q[idx1[PW-1:0]];
  assign free_cnt_o = tail_q - head_q;
  assign head_d     = restore_i ? snap_head_q[restore_tag_i]
                                : head_q + CW'(rn_pop2(alloc_i));

  always_comb begin
    ret_num = '0;
    for (int k = 0; k < CMT_W; k++) begin
      wr_ptr[k] = tail_q + ret_num;
      ret_num   = ret_num + CW'(ret_vld_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= CW'(NFREE);
      for (int i = 0; i < NUM_PHYS; i++)
        fifo_q[i] <= (i < NFREE) ? PW'(i + NUM_AREG) : '0;
      for (int k = 0; k < NUM_SNAP; k++) snap_head_q[k] <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_q + ret_num;
      for (int k = 0; k < CMT_W; k++)
        if (ret_vld_i[k]) fifo_q[wr_ptr[k][PW-1:0]] <= ret_preg_i[k];
      if (snap_take_i) snap_head_q[snap_tag_i] <= head_d;
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int unsigned NUM_AREG = RN_NUM_AREG,
  parameter int unsigned NUM_PHYS = RN_NUM_PHYS,
  parameter int unsigned NUM_SNAP = RN_NUM_SNAP,
  parameter int unsigned CMT_W    = RN_CMT_W,
  localparam int unsigned AW = $clog2(NUM_AREG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned SW = $clog2(NUM_SNAP),
  localparam int unsigned CW = PW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            in_vld_i,
  input  logic [1:0]            in_wr_i,
  input  logic [2*AW-1:0]       in_dst_i,
  input  logic [2*AW-1:0]       in_src1_i,
  input  logic [2*AW-1:0]       in_src2_i,
  output logic                  ready_o,
  output logic [2*PW-1:0]       out_psrc1_o,
  output logic [2*PW-1:0]       out_psrc2_o,
  output logic [2*PW-1:0]       out_pdst_o,
  output logic [2*PW-1:0]       out_pold_o,
  input  logic [CMT_W-1:0]      cmt_vld_i,
  input  logic [CMT_W*PW-1:0]   cmt_preg_i,
  input  logic                  ckpt_req_i,
  output logic [SW-1:0]         ckpt_tag_o,
  input  logic                  ckpt_rel_i,
  input  logic                  flush_i,
  input  logic [SW-1:0]         flush_tag_i
);
  logic [1:0][AW-1:0]       dst, src1, src2;
  logic [1:0]               has_dst, alloc;
  logic [1:0]               need;
  logic [CW-1:0]            free_cnt;
  logic                     snap_full, fire, snap_take;
  logic [SW-1:0]            snap_tag;
  logic [1:0][PW-1:0]       new_p;
  logic [5:0][AW-1:0]       rd_areg;
  logic [5:0][PW-1:0]       rd_preg;
  logic [1:0][PW-1:0]       psrc1, psrc2, pdst, pold;
  logic [CMT_W-1:0][PW-1:0] ret_preg;
  logic                     byp_s1, byp_s2, byp_dst;

  assign dst      = in_dst_i;
  assign src1     = in_src1_i;
  assign src2     = in_src2_i;
  assign ret_preg = cmt_preg_i;

  assign has_dst   = in_vld_i & in_wr_i;
  assign need      = rn_pop2(has_dst);
  assign ready_o   = !flush_i && (free_cnt >= CW'(need)) && !(ckpt_req_i && snap_full);
  assign fire      = ready_o && (in_vld_i != '0);
  assign alloc     = fire ? has_dst : 2'b00;
  assign snap_take = fire && ckpt_req_i;

  // read ports: per slot src1, src2, previous destination
  assign rd_areg = {dst[1], src2[1], src1[1], dst[0], src2[0], src1[0]};

  rn_map_table #(
    .NUM_AREG(NUM_AREG), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP), .NUM_RD(6)
  ) i_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_areg_i    (rd_areg),
    .rd_preg_o    (rd_preg),
    .wr_en_i      (alloc),
    .wr_areg_i    (dst),
    .wr_preg_i    (new_p),
    .snap_take_i  (snap_take),
    .snap_tag_i   (snap_tag),
    .restore_i    (flush_i),
    .restore_tag_i(flush_tag_i)
  );

  rn_free_list #(
    .NUM_AREG(NUM_AREG), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP), .CMT_W(CMT_W)
  ) i_free (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lead_i       (has_dst[0]),
    .alloc_i      (alloc),
    .preg_o       (new_p),
    .free_cnt_o   (free_cnt),
    .ret_vld_i    (cmt_vld_i),
    .ret_preg_i   (ret_preg),
    .snap_take_i  (snap_take),
    .snap_tag_i   (snap_tag),
    .restore_i    (flush_i),
    .restore_tag_i(flush_tag_i)
  );

  rn_snap_ctl #(.NUM_SNAP(NUM_SNAP)) i_snap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (snap_take),
    .rel_i        (ckpt_rel_i),
    .restore_i    (flush_i),
    .restore_tag_i(flush_tag_i),
    .tag_o        (snap_tag),
    .full_o       (snap_full)
  );

  // in-group dependence: slot 1 sees slot 0's new register
  assign byp_s1  = has_dst[0] && (src1[1] == dst[0]);
  assign byp_s2  = has_dst[0] && (src2[1] == dst[0]);
  assign byp_dst = has_dst[0] && (dst[1]  == dst[0]);

  always_comb begin
    psrc1[0] = rd_preg[0];
    psrc2[0] = rd_preg[1];
    pold[0]  = has_dst[0] ? rd_preg[2] : '0;
    psrc1[1] = byp_s1 ? new_p[0] : rd_preg[3];
    psrc2[1] = byp_s2 ? new_p[0] : rd_preg[4];
    pold[1]  = !has_dst[1] ? '0 : (byp_dst ? new_p[0] : rd_preg[5]);
    for (int s = 0; s < 2; s++) pdst[s] = has_dst[s] ? new_p[s] : '0;
  end

  assign out_psrc1_o = psrc1;
  assign out_psrc2_o = psrc2;
  assign out_pdst_o  = pdst;
  assign out_pold_o  = pold;
  assign ckpt_tag_o  = snap_tag;
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned NUM_AREG = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned CMT_W    = 2,
  localparam int unsigned AW    = $clog2(NUM_AREG),
  localparam int unsigned PW    = $clog2(NUM_PHYS),
  localparam int unsigned CW    = PW + 1,
  localparam int unsigned NFREE = NUM_PHYS - NUM_AREG
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        in_vld_i,
  input logic [1:0]        in_wr_i,
  input logic [2*AW-1:0]   in_dst_i,
  input logic [2*AW-1:0]   in_src1_i,
  input logic              ready_o,
  input logic [2*PW-1:0]   out_psrc1_o,
  input logic [2*PW-1:0]   out_pdst_o,
  input logic [2*PW-1:0]   out_pold_o,
  input logic [CMT_W-1:0]  cmt_vld_i,
  input logic              ckpt_req_i,
  input logic              flush_i,
  input logic [1:0]        need,
  input logic [CW-1:0]     free_cnt,
  input logic              snap_full
);
  logic [PW-1:0] pd0, pd1, po0, ps1_1;
  assign pd0   = out_pdst_o[PW-1:0];
  assign pd1   = out_pdst_o[2*PW-1:PW];
  assign po0   = out_pold_o[PW-1:0];
  assign ps1_1 = out_psrc1_o[2*PW-1:PW];

  a_r7_stall_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW'(need) > free_cnt) |-> !ready_o);

  a_r10_flush_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !ready_o);

  a_r9_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt_req_i && snap_full) |-> !ready_o);

  a_r3_distinct_pdst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (&(in_vld_i & in_wr_i))) |-> (pd0 != pd1));

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= CW'(NFREE));

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (in_vld_i != '0) && (cmt_vld_i == '0)) |=>
    (free_cnt == $past(free_cnt) - CW'($past(need))));

  a_r5_bypass_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (in_vld_i == 2'b11) && in_wr_i[0] &&
     (in_src1_i[2*AW-1:AW] == in_dst_i[AW-1:0])) |-> (ps1_1 == pd0));

  a_r4_no_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i[0] && !in_wr_i[0]) |-> (pd0 == '0 && po0 == '0));
endmodule

bind rename_unit rename_unit_chk #(
  .NUM_AREG(NUM_AREG), .NUM_PHYS(NUM_PHYS), .CMT_W(CMT_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_vld_i   (in_vld_i),
  .in_wr_i    (in_wr_i),
  .in_dst_i   (in_dst_i),
  .in_src1_i  (in_src1_i),
  .ready_o    (ready_o),
  .out_psrc1_o(out_psrc1_o),
  .out_pdst_o (out_pdst_o),
  .out_pold_o (out_pold_o),
  .cmt_vld_i  (cmt_vld_i),
  .ckpt_req_i (ckpt_req_i),
  .flush_i    (flush_i),
  .need       (need),
  .free_cnt   (free_cnt),
  .snap_full  (snap_full)
);

// File: tb/test_rename_unit.sv
`timescale 1ns/1ps
module test_rename_unit;
  localparam int NA = 8, NP = 32, NS = 4, AW = 3, PW = 5, SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] vld, wr, cv;
  int ta[2], tb[2], td[2], cp[2], ft;
  logic ck, rl, fl;

  logic          ready_o;
  logic [2*PW-1:0] psrc1, psrc2, pdst, pold;
  logic [SW-1:0]   tag;

  rename_unit i_rename_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .in_vld_i(vld), .in_wr_i(wr),
    .in_dst_i({td[1][AW-1:0], td[0][AW-1:0]}),
    .in_src1_i({ta[1][AW-1:0], ta[0][AW-1:0]}),
    .in_src2_i({tb[1][AW-1:0], tb[0][AW-1:0]}),
    .ready_o(ready_o),
    .out_psrc1_o(psrc1), .out_psrc2_o(psrc2), .out_pdst_o(pdst), .out_pold_o(pold),
    .cmt_vld_i(cv), .cmt_preg_i({cp[1][PW-1:0], cp[0][PW-1:0]}),
    .ckpt_req_i(ck), .ckpt_tag_o(tag), .ckpt_rel_i(rl),
    .flush_i(fl), .flush_tag_i(ft[SW-1:0])
  );

  typedef struct {
    bit rdy; bit [1:0] v; bit [1:0] w; bit ck; int tag; string req;
    logic [1:0][PW-1:0] s1, s2, pd, po;
  } exp_t;

  exp_t sbq[$];
  event smp;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  int mp[NA];
  int fq[$];
  int alog[$];
  int smap[NS][NA];
  int slog[NS];
  int s_old = 0, s_cnt = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    vld = 0; wr = 0; cv = 0; ck = 0; rl = 0; fl = 0; ft = 0;
    for (int s = 0; s < 2; s++) begin ta[s] = 0; tb[s] = 0; td[s] = 0; cp[s] = 0; end
  endtask

  task automatic slot(int i, bit v, bit w, int d, int a, int b);
    vld[i] = v; wr[i] = w; td[i] = d; ta[i] = a; tb[i] = b;
  endtask

  task automatic step(string req);
    exp_t e;
    int need, np0, np1, k1, tg;
    bit h0, h1, fire;
    @(negedge clk);
    h0 = vld[0] && wr[0];
    h1 = vld[1] && wr[1];
    need = int'(h0) + int'(h1);
    e.req = req; e.v = vld; e.w = wr; e.ck = ck;
    e.rdy = !fl && (need <= fq.size()) && !(ck && s_cnt == NS);
    k1  = h0 ? 1 : 0;
    np0 = fq.size() > 0  ? fq[0]  : 0;
    np1 = fq.size() > k1 ? fq[k1] : 0;
    e.s1[0] = PW'(mp[ta[0]]);
    e.s2[0] = PW'(mp[tb[0]]);
    e.pd[0] = h0 ? PW'(np0) : '0;
    e.po[0] = h0 ? PW'(mp[td[0]]) : '0;
    e.s1[1] = (h0 && ta[1] == td[0]) ? PW'(np0) : PW'(mp[ta[1]]);
    e.s2[1] = (h0 && tb[1] == td[0]) ? PW'(np0) : PW'(mp[tb[1]]);
    e.pd[1] = h1 ? PW'(np1) : '0;
    e.po[1] = !h1 ? '0 : ((h0 && td[1] == td[0]) ? PW'(np0) : PW'(mp[td[1]]));
    tg = (s_old + s_cnt) % NS;
    e.tag = tg;
    sbq.push_back(e);
    ->smp;
    @(posedge clk);
    fire = e.rdy && (vld != 0);
    if (fire) begin
      if (h0) begin alog.push_back(fq.pop_front()); mp[td[0]] = np0; end
      if (h1) begin alog.push_back(fq.pop_front()); mp[td[1]] = np1; end
      if (ck) begin
        for (int k = 0; k < NA; k++) smap[tg][k] = mp[k];
        slog[tg] = alog.size();
        s_cnt++;
      end
    end
    for (int c = 0; c < 2; c++) if (cv[c]) fq.push_back(cp[c]);
    if (fl) begin
      while (alog.size() > slog[ft]) fq.push_front(alog.pop_back());
      for (int k = 0; k < NA; k++) mp[k] = smap[ft][k];
      s_cnt = (ft - s_old + NS) % NS;
    end else if (rl && s_cnt > 0) begin
      s_old = (s_old + 1) % NS;
      s_cnt--;
    end
    #1 clr();
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(smp);
      e = sbq.pop_front();
      chk(e.req, "ready", int'(ready_o), int'(e.rdy));
      if (e.rdy && e.v != 0) begin
        for (int s = 0; s < 2; s++) if (e.v[s]) begin
          chk(e.req, "psrc1", int'(psrc1[s*PW +: PW]), int'(e.s1[s]));
          chk(e.req, "psrc2", int'(psrc2[s*PW +: PW]), int'(e.s2[s]));
          chk(e.req, "pdst",  int'(pdst[s*PW +: PW]),  int'(e.pd[s]));
          chk(e.req, "pold",  int'(pold[s*PW +: PW]),  int'(e.po[s]));
        end
        if (e.ck) chk(e.req, "ckpt_tag", int'(tag), e.tag);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    for (int i = 0; i < NA; i++) mp[i] = i;
    for (int i = NA; i < NP; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready_after_reset", int'(ready_o), 1);

    // R1: identity mapping, read all eight registers
    for (int i = 0; i < 2; i++) begin
      slot(0, 1, 0, 0, 4*i, 4*i+1);
      slot(1, 1, 0, 0, 4*i+2, 4*i+3);
      step("R1");
    end
    // R3: first allocations come out 8, 9
    slot(0, 1, 1, 3, 0, 1); slot(1, 1, 1, 6, 2, 7); step("R3");
    // R2: new mapping visible next cycle
    slot(0, 1, 0, 0, 3, 6); step("R2");
    // R5: slot 1 reads slot 0's destination on both sources
    slot(0, 1, 1, 1, 2, 3); slot(1, 1, 1, 7, 1, 1); step("R5");
    // R6: same destination in both slots, then read it back
    slot(0, 1, 1, 2, 0, 0); slot(1, 1, 1, 2, 2, 5); step("R6");
    slot(0, 1, 0, 0, 2, 2); step("R6");
    // R4: slot 0 writes nothing, slot 1 gets the head
    slot(0, 1, 0, 5, 4, 5); slot(1, 1, 1, 0, 5, 0); step("R4");
    // R4: slot 0 empty, only slot 1 allocates
    slot(1, 1, 1, 4, 1, 2); step("R4");

    // R9: checkpoint with a branch group
    slot(0, 1, 1, 1, 0, 2); ck = 1; step("R9");
    slot(0, 1, 1, 1, 3, 4); slot(1, 1, 1, 2, 1, 1); step("R10");
    // R10: flush drops the group in the same cycle
    slot(0, 1, 1, 3, 0, 0); fl = 1; ft = 0; step("R10");
    // R10: mapping and allocation order are back to the snapshot
    slot(0, 1, 1, 1, 1, 2); slot(1, 1, 1, 2, 1, 2); step("R10");
    // R9: fill all four snapshots, the fifth stalls
    for (int i = 0; i < 4; i++) begin
      slot(0, 1, 1, i, i, 7); ck = 1; step("R9");
    end
    slot(0, 1, 1, 5, 5, 6); ck = 1; step("R9");
    // R11: release the oldest, the tag wraps
    rl = 1; step("R11");
    slot(0, 1, 1, 6, 6, 0); ck = 1; step("R11");
    // R11: release ignored during a flush to a middle tag
    fl = 1; ft = 2; rl = 1; step("R11");
    for (int i = 0; i < 4; i++) begin
      slot(0, 1, 1, 7, 7, i); ck = 1; step("R11");
    end
    while (s_cnt > 0) begin rl = 1; step("R11"); end
    slot(0, 1, 1, 0, 1, 2); ck = 1; step("R9");

    // R7: drain the free queue
    while (fq.size() >= 2) begin
      slot(0, 1, 1, 4, 0, 1); slot(1, 1, 1, 5, 4, 3); step("R3");
    end
    slot(0, 1, 1, 6, 4, 5); slot(1, 1, 1, 7, 6, 7); step("R7");
    slot(0, 1, 0, 0, 6, 7); slot(1, 1, 0, 0, 4, 5); step("R7");
    // R7/R8: commits in the stalled cycle do not count yet
    slot(0, 1, 1, 6, 0, 1); slot(1, 1, 1, 7, 2, 3);
    cv = 2'b11; cp[0] = 4; cp[1] = 5; step("R7");
    // R8: returned registers appended in lane order
    slot(0, 1, 1, 6, 0, 1); slot(1, 1, 1, 7, 2, 3); step("R8");
    cv = 2'b10; cp[1] = 6; step("R8");
    slot(0, 1, 0, 0, 6, 7); slot(1, 1, 1, 3, 6, 7); step("R8");

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule